// File: doc/BRIEF.md
# Four-Master Shared Memory Bus Arbiter

This block lets four masters share one single-port synchronous memory. Three of them are streaming writers: a compressed-video writer, a raw-video frame writer and an audio buffer writer. Each pushes (address, data) words into a small FIFO of its own. The fourth is a CPU with a blocking read/write handshake. The memory lives inside the block and takes a fixed number of cycles (`ACC`) to finish each word.

The next owner is chosen during the current owner's last cycle. Ownership moves on the same clock edge that ends that word, so a busy bus loses no cycles to arbitration. An owner keeps the bus while it has words queued. It gives the bus up early if another master's FIFO becomes nearly full, or if its hold timer runs out while someone else is waiting. The bus lines to the memory are an AND-OR selection of the granted master's signals. They read as all zero when nobody owns the bus.

Top module: `mem_arbiter`

## Requirements
- R1: After reset, all grant lines are low, all overflow flags are clear, `cpu_ack` is low and `mem_we` is low.
- R2: Each streaming master's accepted words reach the memory in push order, at the address and with the data given at push time. A stream requests the bus whenever its FIFO holds at least one word.
- R3: When no master owns the bus, every grant line is low and `mem_we`, `mem_addr` and `mem_wdata` are zero. A request present at an idle bus is granted on the next clock edge.
- R4: At most one grant line is high. A word lasts `ACC` cycles. The grant changes only on the edge that ends a word, or on an edge while the bus is idle. If another master is waiting when a word ends, it is granted on that same edge, with no idle cycle.
- R5: A new owner is chosen by round-robin in index order 0,1,2,3 (streams 0..2, then the CPU as index 3), starting after the last granted master. After reset the search begins at index 0.
- R6: An owner that still has words after the current one keeps the bus, unless R7 or R8 forces it off.
- R7: The 8-bit hold timer loads `hold_limit` on each new grant. It then decrements on every cycle in which another master requests and the timer is non-zero. If the timer is zero at the end of a word and another master requests, the owner loses the bus.
- R8: A stream whose FIFO holds at least three quarters of its depth (6 of 8 words) is urgent. Urgent masters are chosen before all others, and an urgent non-owner ends the current owner's tenure at the next word end.
- R9: The CPU holds `cpu_req` until `cpu_ack`. `cpu_ack` is a one-cycle pulse at the end of the CPU's word, `ACC`+1 cycles after the request on an idle bus. `cpu_rdata` holds the addressed memory word while `cpu_ack` is high. `cpu_we`=1 writes `cpu_wdata`.
- R10: A push into a full FIFO (8 words) is dropped and sets that stream's overflow flag, which stays set until reset. Under a total stream load below the memory word rate, no flag sets.
- R11: While a master owns the bus, `mem_we`, `mem_addr` and `mem_wdata` equal that master's write enable, address and data (streams always write, using their FIFO head).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_push | input | NS | Per-stream push strobe |
| s_addr | input | NS*AW | Per-stream push address, stream i at bits i*AW |
| s_data | input | NS*DW | Per-stream push data, stream i at bits i*DW |
| cpu_req | input | 1 | CPU request, held until acknowledge |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_ack | output | 1 | One-cycle CPU completion pulse |
| cpu_rdata | output | DW | CPU read data, valid with cpu_ack |
| hold_limit | input | TW | Hold timer load value |
| grant | output | NS+1 | One-hot owner, bit 3 is the CPU |
| mem_we | output | 1 | Memory write enable of the owner |
| mem_addr | output | AW | Memory address of the owner |
| mem_wdata | output | DW | Memory write data of the owner |
| ovf | output | NS | Sticky FIFO overflow flags |

## Verification
Some properties are checked on every cycle: the grant stays one-hot or empty, it stays still in the middle of a word, an idle bus with a pending request is picked up on the next edge, and a waiting master takes over at a word end with no idle gap. The same checks cover the all-zero bus when idle, the single-cycle acknowledge and the sticky overflow flags. Other behaviour only shows in the bench's scenarios: the round-robin order, how the hold timer shapes the order of words, an urgent stream cutting in before the owner empties, push-order delivery, and the read-back of memory contents.

// File: rtl/mem_arbiter.sv
module mem_arbiter #(
  parameter int DW  = 16,
  parameter int AW  = 8,
  parameter int NS  = 3,
  parameter int FD  = 8,
  parameter int ACC = 2,
  parameter int TW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   s_push,
  input  logic [NS*AW-1:0] s_addr,
  input  logic [NS*DW-1:0] s_data,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_ack,
  output logic [DW-1:0]   cpu_rdata,
  input  logic [TW-1:0]   hold_limit,
  output logic [NS:0]     grant,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [NS-1:0]   ovf
);
  localparam int NM    = NS + 1;
  localparam int CPU   = NS;
  localparam int IW    = $clog2(NM);
  localparam int FAW   = $clog2(FD);
  localparam int PW    = (ACC > 1) ? $clog2(ACC) : 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [FAW:0] FULL_N = (FAW+1)'(FD);
  localparam logic [FAW:0] URG_N  = (FAW+1)'((FD * 3) / 4);

  logic [NM-1:0] req, urg, more, m_we, nxt, pool, others;
  logic [AW-1:0] m_addr [NM];
  logic [DW-1:0] m_data [NM];
  logic [PW-1:0] ph;
  logic [TW-1:0] tmo;
  logic [IW-1:0] last;
  logic          busy, done, oth_any, oth_urg, own_more;

  assign busy     = |grant;
  assign done     = busy && (ph == PW'(ACC - 1));
  assign others   = req & ~grant;
  assign oth_any  = |others;
  assign oth_urg  = |(urg & others);
  assign own_more = |(grant & more);

  for (genvar i = 0; i < NS; i++) begin : g_fifo
    logic [AW+DW-1:0] q [FD];
    logic [FAW:0]     n;
    logic [FAW-1:0]   wp, rp;
    logic             of, full, acc, pop;

    assign full = (n == FULL_N);
    assign acc  = s_push[i] & ~full;
    assign pop  = done & grant[i];

    always_ff @(posedge clk) if (acc) q[wp] <= {s_addr[i*AW +: AW], s_data[i*DW +: DW]};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        n <= '0; wp <= '0; rp <= '0; of <= 1'b0;
      end else begin
        if (acc) wp <= wp + 1'b1;
        if (pop) rp <= rp + 1'b1;
        n  <= n + {{FAW{1'b0}}, acc} - {{FAW{1'b0}}, pop};
        of <= of | (s_push[i] & full);
      end

    assign req[i]    = (n != '0);
    assign urg[i]    = (n >= URG_N);
    assign more[i]   = (n > (FAW+1)'(1));
    assign m_we[i]   = 1'b1;
    assign m_addr[i] = q[rp][AW+DW-1:DW];
    assign m_data[i] = q[rp][DW-1:0];
    assign ovf[i]    = of;
  end

  assign req[CPU]    = cpu_req & ~cpu_ack;
  assign urg[CPU]    = 1'b0;
  assign more[CPU]   = 1'b0;
  assign m_we[CPU]   = cpu_we;
  assign m_addr[CPU] = cpu_addr;
  assign m_data[CPU] = cpu_wdata;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < NM; i++) begin
      mem_we    = mem_we | (grant[i] & m_we[i]);
      mem_addr  = mem_addr | ({AW{grant[i]}} & m_addr[i]);
      mem_wdata = mem_wdata | ({DW{grant[i]}} & m_data[i]);
    end
  end

  function automatic logic [NM-1:0] pick(input logic [NM-1:0] s, input logic [IW-1:0] from);
    int j;
    pick = '0;
    for (int k = NM; k >= 1; k--) begin
      j = (int'(from) + k) % NM;
      if (s[j]) pick = {{(NM-1){1'b0}}, 1'b1} << j;
    end
  endfunction

  function automatic logic [IW-1:0] idx(input logic [NM-1:0] g);
    idx = '0;
    for (int i = 0; i < NM; i++) if (g[i]) idx = IW'(i);
  endfunction

  always_comb begin
    pool = busy ? others : req;
    if (|(pool & urg)) pool = pool & urg;
    nxt = grant;
    if (!busy)
      nxt = pick(pool, last);
    else if (done) begin
      if (own_more && !(oth_any && tmo == '0) && !oth_urg) nxt = grant;
      else if (pool != '0)                                  nxt = pick(pool, last);
      else if (own_more)                                    nxt = grant;
      else                                                  nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grant <= '0;
      last  <= IW'(NM - 1);
      ph    <= '0;
      tmo   <= '0;
    end else begin
      grant <= nxt;
      ph    <= (!busy || done) ? '0 : ph + 1'b1;
      if (nxt != grant && nxt != '0) begin
        last <= idx(nxt);
        tmo  <= hold_limit;
      end else if (busy && oth_any && tmo != '0)
        tmo <= tmo - 1'b1;
    end

  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge clk) if (done && mem_we) mem[mem_addr] <= mem_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= done & grant[CPU];
      if (done & grant[CPU]) cpu_rdata <= mem[mem_addr];
    end
endmodule

// File: rtl/mem_arbiter_checks.sv
module mem_arbiter_checks #(
  parameter int NM = 4,
  parameter int NS = 3,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] grant,
  input logic [NM-1:0] req,
  input logic          done,
  input logic          cpu_ack,
  input logic [NS-1:0] ovf,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R4
  AST_HOLD_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n) (grant != '0 && !done) |=> $stable(grant)); // R4
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (done && (req & ~grant) != '0) |=> grant != '0); // R4
  AST_IDLE_PICKUP: assert property (@(posedge clk) disable iff (!rst_n) (grant == '0 && req != '0) |=> grant != '0); // R3
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) (grant == '0) |-> (!mem_we && mem_addr == '0)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpu_ack |=> !cpu_ack); // R9
  for (genvar i = 0; i < NS; i++) begin : g_ovf
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf[i] |=> ovf[i]); // R10
  end
endmodule

bind mem_arbiter mem_arbiter_checks #(.NM(NS+1), .NS(NS), .AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .done(done),
  .cpu_ack(cpu_ack), .ovf(ovf), .mem_we(mem_we), .mem_addr(mem_addr));

// File: tb/mem_arbiter_test.sv
`timescale 1ns/1ps
module mem_arbiter_test;
  localparam int DW = 16, AW = 8, NS = 3, FD = 8, ACC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [NS-1:0] s_push;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_data;
  logic cpu_req, cpu_we, cpu_ack;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic [7:0] hold_limit;
  logic [NS:0] grant;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NS-1:0] ovf;

  mem_arbiter uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [AW+DW-1:0] bq [NS][16];
  int hd [NS], tl [NS], seq [NS];
  bit ovf_exp [NS];
  int pend = -1;
  int ph_b = 0;
  logic [DW-1:0] ref_mem [256];
  bit ref_ok [256];
  int wlog [16];
  int wn = 0;
  bit logging = 0, urg_watch = 0, urg_seen = 0, rnd_done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mc(input int i);
    return tl[i] - hd[i];
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int g;
      if (pend >= 0) begin hd[pend]++; pend = -1; end
      for (int i = 0; i < NS; i++) chk("R10 overflow flag", int'(ovf[i]), int'(ovf_exp[i]));
      if (grant == '0) ph_b = 0;
      else begin
        g = 0;
        for (int i = 0; i <= NS; i++) if (grant[i]) g = i;
        if (g < NS) begin
          chk("R2 granted stream holds a word", int'(mc(g) > 0), 1);
          chk("R11 bus carries stream FIFO head", int'({mem_we, mem_addr, mem_wdata}),
              int'({1'b1, bq[g][hd[g] % 16]}));
        end else
          chk("R11 bus carries CPU lines", int'({mem_we, mem_addr, mem_wdata}),
              int'({cpu_we, cpu_addr, cpu_wdata}));
        if (urg_watch && g == 1 && !urg_seen) begin
          urg_seen = 1;
          chk("R8 urgent stream preempts non-empty owner", int'(mc(0) > 0), 1);
        end
        if (ph_b == ACC - 1) begin
          if (g < NS) pend = g;
          if (logging && wn < 16) begin wlog[wn] = g; wn++; end
          ph_b = 0;
        end else ph_b++;
      end
    end
  end

  task automatic step_push(input logic [NS-1:0] m);
    @(negedge clk);
    s_push = '0;
    for (int i = 0; i < NS; i++) if (m[i]) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'(i * 64 + (seq[i] % 64));
      d = DW'($urandom);
      seq[i]++;
      s_push[i] = 1'b1;
      s_addr[i*AW +: AW] = a;
      s_data[i*DW +: DW] = d;
      if (mc(i) >= FD) ovf_exp[i] = 1;
      else begin
        bq[i][tl[i] % 16] = {a, d};
        tl[i]++;
        ref_mem[a] = d;
        ref_ok[a] = 1;
      end
    end
  endtask

  task automatic drain();
    int guard;
    step_push('0);
    guard = 0;
    while ((grant != '0 || mc(0) > 0 || mc(1) > 0 || mc(2) > 0) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 1000);
    rd = cpu_rdata;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we) begin ref_mem[a] = d; ref_ok[a] = 1; end
  endtask

  task automatic order_case(input logic [7:0] lim, input logic [NS-1:0] m, input int reps,
                            input int e0, input int e1, input int e2, input int e3,
                            input int e4, input int e5, input string tag);
    int e [6];
    e = '{e0, e1, e2, e3, e4, e5};
    hold_limit = lim;
    wn = 0;
    logging = 1;
    for (int r = 0; r < reps; r++) step_push(m);
    drain();
    logging = 0;
    chk({tag, " word count"}, wn, 6);
    for (int k = 0; k < 6; k++) chk({tag, " word owner"}, wlog[k], e[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin hd[i] = 0; tl[i] = 0; seq[i] = 0; ovf_exp[i] = 0; end
    rst_n = 1'b0; s_push = '0; s_addr = '0; s_data = '0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; hold_limit = 8'd255;
    repeat (3) @(negedge clk);
    chk("R1 grant after reset", int'(grant), 0);
    chk("R1 ovf after reset", int'(ovf), 0);
    chk("R1 ack after reset", int'(cpu_ack), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 idle pickup and R4 word length
    step_push(3'b001);
    step_push('0);
    chk("R3 not granted before request seen", int'(grant), 0);
    @(negedge clk);
    chk("R3 granted one edge after request", int'(grant), 1);
    @(negedge clk);
    chk("R4 grant held through word", int'(grant), 1);
    @(negedge clk);
    chk("R4 released after ACC cycles", int'(grant), 0);
    chk("R3 idle bus zero", int'({mem_we, mem_addr, mem_wdata}), 0);

    // R9 CPU handshake
    cpu_op(1, 8'd200, 16'hBEEF, rd, lat);
    chk("R9 write latency on idle bus", lat, ACC + 1);
    @(negedge clk);
    chk("R9 ack single pulse", int'(cpu_ack), 0);
    chk("R9 no regrant after ack", int'(grant), 0);
    cpu_op(0, 8'd200, 16'h0, rd, lat);
    chk("R9 read data with ack", int'(rd), 16'hBEEF);
    chk("R9 read latency on idle bus", lat, ACC + 1);

    // R5 R6 R7 ordering
    order_case(8'd255, 3'b111, 2, 0, 0, 1, 1, 2, 2, "R6 owner keeps bus");
    order_case(8'd0,   3'b111, 2, 0, 1, 2, 0, 1, 2, "R5 R7 zero timer rotation");
    order_case(8'd3,   3'b011, 3, 0, 0, 1, 1, 0, 1, "R7 timer counts under contention");

    // R8 urgent
    hold_limit = 8'd255;
    urg_watch = 1;
    for (int c = 0; c < 6; c++) step_push(3'b011);
    for (int c = 0; c < 2; c++) step_push(3'b001);
    drain();
    urg_watch = 0;
    chk("R8 urgent stream granted", int'(urg_seen), 1);

    // random mixed load, R10 no overflow under load
    hold_limit = 8'd4;
    fork
      begin
        for (int c = 0; c < 2500; c++) begin
          logic [NS-1:0] m;
          for (int i = 0; i < NS; i++) m[i] = (($urandom % 12) == 0);
          step_push(m);
        end
        step_push('0);
        rnd_done = 1;
      end
      begin
        while (!rnd_done) begin
          logic [AW-1:0] a;
          repeat ($urandom_range(10, 40)) @(negedge clk);
          if (!rnd_done) begin
            a = AW'(192 + ($urandom % 64));
            if (ref_ok[a] && ($urandom % 2) == 0) begin
              cpu_op(0, a, '0, rd, lat);
              chk("R9 random CPU read", int'(rd), int'(ref_mem[a]));
            end else
              cpu_op(1, a, DW'($urandom), rd, lat);
          end
        end
      end
    join
    drain();
    chk("R10 no overflow below word rate", int'(ovf), 0);

    // R10 overflow on burst into stream 2
    hold_limit = 8'd255;
    for (int c = 0; c < 20; c++) step_push(3'b100);
    drain();
    chk("R10 overflow flag set", int'(ovf[2]), 1);
    repeat (5) @(negedge clk);
    chk("R10 overflow flag sticky", int'(ovf[2]), 1);

    // R2 memory contents
    for (int i = 0; i < NS; i++) begin
      int got = 0;
      for (int k = 0; k < 64 && got < 4; k++) begin
        logic [AW-1:0] a;
        a = AW'(i * 64 + k);
        if (ref_ok[a]) begin
          cpu_op(0, a, '0, rd, lat);
          chk("R2 stream data in memory", int'(rd), int'(ref_mem[a]));
          got++;
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule